// File: doc/BRIEF.md
# Memory-Type-Aware Write Buffer

This block sits between a processor's single request port (data loads, data stores and instruction fetches) and one downstream memory bus. It decodes each request address into a memory class (Normal, Device or Strongly Ordered) and an execute-never flag. Writes to Normal and Device memory are posted into a four-entry FIFO. Writes to Strongly Ordered memory, and all reads and fetches, go straight to the bus. Whether they may go is decided from their class and from what the FIFO still holds.

Normal reads may overtake posted writes unless one of those writes targets the same 32-bit word. Device accesses keep their order against Device writes that are still buffered. Strongly Ordered accesses wait until the FIFO is empty. A fetch from an execute-never region is performed normally and its response is tagged. The fault output fires only when the processor later signals that it is executing the tagged word.

The bus handshake completes a transfer in the cycle where `bus_valid` and `bus_ready` are both high. For reads, `bus_rdata` is valid in that same cycle.

Top module: `typed_write_buffer`

## Requirements
- R1: Addresses with top three bits 000, 001, 011 or 100 (0x0000_0000–0x3FFF_FFFF and 0x6000_0000–0x9FFF_FFFF) are Normal and executable: a write there is accepted into an empty FIFO even while `bus_ready` is low, and a fetch there returns `rsp_xn`=0.
- R2: Addresses 0x4000_0000–0x5FFF_FFFF (top bits 010) are Device and execute-never: a write there is posted, and a fetch there returns `rsp_xn`=1.
- R3: Addresses from 0xA000_0000 upward (top bits 101–111) are Strongly Ordered and execute-never: a write there is never posted (`req_ready` stays low while `bus_ready` is low), and a fetch there returns `rsp_xn`=1.
- R4: The FIFO holds four posted writes. A fifth write stalls with `req_ready` low until an entry retires. Posted writes reach the bus in acceptance order.
- R5: A Strongly Ordered write is issued only after every buffered write has retired. Its `req_ready` rises in the cycle in which it completes on the bus.
- R6: A Device read or fetch is not issued while any Device write remains buffered. It may pass buffered Normal writes that were posted after the last Device write.
- R7: A Strongly Ordered read waits until the FIFO is empty.
- R8: A Normal read whose word matches no buffered write goes to the bus ahead of the buffered writes.
- R9: A Normal read whose word (address bits 31:2) matches a buffered write stalls until that entry retires, and then returns the written data. Writes queued behind that entry may still follow the read.
- R10: A read or fetch raises `rsp_valid` for exactly one cycle, one cycle after its bus completion, with the bus data. `rsp_xn` is 0 for data reads.
- R11: A fetch never raises `xn_fault`. The cycle after `exec_strobe` is high, `xn_fault` is high exactly when the most recent fetch was tagged execute-never.
- R12: After reset the FIFO is empty and `bus_valid`, `rsp_valid` and `xn_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| req_strb | input | DW/8 | Store byte enables |
| rsp_valid | output | 1 | Read or fetch data returned |
| rsp_rdata | output | DW | Returned data |
| rsp_xn | output | 1 | Returned fetch word is execute-never |
| exec_strobe | input | 1 | Processor executes the last fetched word |
| xn_fault | output | 1 | Execute-never fault pulse |
| bus_valid | output | 1 | Bus transfer requested |
| bus_ready | input | 1 | Bus completes the transfer this cycle |
| bus_write | output | 1 | Bus transfer is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_strb | output | DW/8 | Bus byte enables |
| bus_rdata | input | DW | Bus read data |

## Verification
The embedded properties hold on every cycle for these rules:
- a Strongly Ordered write appears on the bus only with an empty FIFO;
- a directly issued Device access never coexists with a buffered Device write;
- a directly issued Normal read never shares its word with a buffered write;
- a response always follows a completed bus read;
- a fault always follows an execute strobe.

Only the bench's scenarios can show the rest. These are the exact interleavings on the bus: whether a read really overtakes Normal writes, the head-match corner, and the FIFO order under a fifth-write stall. They also include the address-map decode at each region boundary and the data returned after a hazard.

// File: rtl/typed_write_buffer.sv
`timescale 1ns/1ps
module typed_write_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4   // power of two
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_fetch,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_strb,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_xn,
  input  logic            exec_strobe,
  output logic            xn_fault,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_strb,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int SW = DW/8;
  localparam logic [1:0] MT_NORM = 2'd0;
  localparam logic [1:0] MT_DEV  = 2'd1;
  localparam logic [1:0] MT_SO   = 2'd2;

  function automatic logic [1:0] mem_class(input logic [2:0] top);
    case (top)
      3'd0, 3'd1, 3'd3, 3'd4: mem_class = MT_NORM;
      3'd2:                   mem_class = MT_DEV;
      default:                mem_class = MT_SO;
    endcase
  endfunction

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [SW-1:0]    q_strb [DEPTH];
  logic [DEPTH-1:0] q_vld, q_dev, q_hit;
  logic [PW-1:0]    wp, rp;
  logic             last_tag;

  logic [1:0] req_cls, bus_cls;
  logic       posts, full, empty, hit, dev_pend, direct_ok, dir_sel, drain, push, pop;

  assign req_cls = mem_class(req_addr[AW-1:AW-3]);
  assign bus_cls = mem_class(bus_addr[AW-1:AW-3]);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign q_hit[gi] = q_vld[gi] && (q_addr[gi][AW-1:2] == req_addr[AW-1:2]);
    end
  endgenerate

  assign full     = &q_vld;
  assign empty    = ~|q_vld;
  assign hit      = |q_hit;
  assign dev_pend = |(q_vld & q_dev);
  assign posts    = req_write && (req_cls != MT_SO);

  always_comb begin
    direct_ok = 1'b0;
    if (!posts) begin
      case (req_cls)
        MT_NORM: direct_ok = !hit;
        MT_DEV:  direct_ok = !dev_pend;
        default: direct_ok = empty;
      endcase
    end
  end

  assign dir_sel   = req_valid && direct_ok;
  assign drain     = !dir_sel && !empty;
  assign push      = req_valid && posts && !full;
  assign pop       = drain && bus_ready;
  assign req_ready = posts ? !full : (direct_ok && bus_ready);

  assign bus_valid = dir_sel || drain;
  assign bus_write = dir_sel ? req_write : 1'b1;
  assign bus_addr  = dir_sel ? req_addr  : q_addr[rp];
  assign bus_wdata = dir_sel ? req_wdata : q_data[rp];
  assign bus_strb  = dir_sel ? req_strb  : q_strb[rp];

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= req_addr;
      q_data[wp] <= req_wdata;
      q_strb[wp] <= req_strb;
      q_dev[wp]  <= (req_cls == MT_DEV);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld     <= '0;
      wp        <= '0;
      rp        <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_xn    <= 1'b0;
      last_tag  <= 1'b0;
      xn_fault  <= 1'b0;
    end else begin
      if (push) begin
        q_vld[wp] <= 1'b1;
        wp        <= wp + 1'b1;
      end
      if (pop) begin
        q_vld[rp] <= 1'b0;
        rp        <= rp + 1'b1;
      end
      rsp_valid <= dir_sel && bus_ready && !req_write;
      if (dir_sel && bus_ready && !req_write) begin
        rsp_rdata <= bus_rdata;
        rsp_xn    <= req_fetch && (req_cls != MT_NORM);
        if (req_fetch) last_tag <= (req_cls != MT_NORM);
      end
      xn_fault <= exec_strobe && last_tag;
    end
  end

  // R5
  so_write_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_cls == MT_SO) |-> empty);

  // R6
  dev_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !drain && bus_cls == MT_DEV) |-> !dev_pend);

  // R9
  raw_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !drain && bus_cls == MT_NORM) |-> !hit);

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && posts && (&q_vld)) |-> !req_ready);

  // R10
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && bus_ready && !bus_write));

  // R11
  fault_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xn_fault |-> $past(exec_strobe));
endmodule

// File: tb/tb_typed_write_buffer.sv
`timescale 1ns/1ps
module tb_typed_write_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_strb = 4'hF;
  logic exec_strobe = 1'b0, bus_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_xn, xn_fault, bus_valid, bus_write;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_strb;

  int checks = 0, errors = 0;
  logic [31:0] mem [16];
  logic [15:0] mw = '0;
  logic [31:0] log_a [64];
  int log_n = 0;

  always #2.5 clk = ~clk;

  typed_write_buffer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_xn(rsp_xn), .exec_strobe(exec_strobe),
    .xn_fault(xn_fault), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_rdata(bus_rdata));

  assign bus_rdata = mw[bus_addr[5:2]] ? mem[bus_addr[5:2]] : {28'hC0DE000, bus_addr[5:2]};

  always @(negedge clk) begin
    if (bus_valid && bus_ready) begin
      if (log_n < 64) log_a[log_n] = bus_addr;
      log_n = log_n + 1;
      if (bus_write) begin
        mem[bus_addr[5:2]] = bus_wdata;
        mw[bus_addr[5:2]]  = 1'b1;
      end
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic req_wait(input logic wr, input logic fe, input logic [31:0] a,
                          input logic [31:0] d, output int waited, output logic [31:0] seen);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_fetch = fe; req_addr = a; req_wdata = d;
    waited = 0;
    @(negedge clk);
    while (!req_ready) begin waited++; @(negedge clk); end
    seen = (bus_valid && bus_ready) ? bus_addr : 32'hFFFF_FFFF;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
  endtask

  task automatic probe_write(input logic [31:0] a, output logic rdy);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_fetch = 1'b0; req_addr = a; req_wdata = a;
    @(negedge clk);
    rdy = req_ready;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic settle();
    bus_ready = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic raise_ready_after(input int n);
    repeat (n) @(posedge clk);
    #1 bus_ready = 1'b1;
  endtask

  // {address, expected execute-never tag, expected posted}
  localparam logic [33:0] VEC [10] = '{
    {32'h0000_0100, 1'b0, 1'b1}, {32'h1FFF_FFFC, 1'b0, 1'b1},
    {32'h2000_0040, 1'b0, 1'b1}, {32'h3FFF_FFF0, 1'b0, 1'b1},
    {32'h4000_0000, 1'b1, 1'b1}, {32'h5FFF_FFFC, 1'b1, 1'b1},
    {32'h6000_0000, 1'b0, 1'b1}, {32'h9FFF_FFFC, 1'b0, 1'b1},
    {32'hA000_0000, 1'b1, 1'b0}, {32'hFFFF_FFFC, 1'b1, 1'b0}};

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] va, seen;
    logic rdy;
    string rq;
    int w, base;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12
    check("R12", {31'd0, bus_valid}, 32'd0);
    check("R12", {31'd0, rsp_valid}, 32'd0);
    check("R12", {31'd0, xn_fault}, 32'd0);

    // R1 R2 R3: decode table walk
    for (int k = 0; k < 10; k++) begin
      va = VEC[k][33:2];
      rq = VEC[k][1] ? (VEC[k][0] ? "R2" : "R3") : "R1";
      bus_ready = 1'b0;
      probe_write(va, rdy);
      check(rq, {31'd0, rdy}, {31'd0, VEC[k][0]});
      settle();
      req_wait(1'b0, 1'b1, va, '0, w, seen);
      @(negedge clk);
      check(rq, {30'd0, rsp_valid, rsp_xn}, {30'd0, 1'b1, VEC[k][1]});
    end

    // R4: four entries, fifth stalls, order kept
    bus_ready = 1'b0;
    base = log_n;
    for (int i = 0; i < 4; i++) begin
      req_wait(1'b1, 1'b0, 32'h2000_0000 + 32'(i*4), 32'h100 + 32'(i), w, seen);
      check("R4", w, 0);
    end
    fork
      req_wait(1'b1, 1'b0, 32'h0000_0010, 32'h104, w, seen);
      raise_ready_after(4);
    join
    check("R4", {31'd0, (w >= 3)}, 32'd1);
    settle();
    for (int i = 0; i < 4; i++) check("R4", log_a[base+i], 32'h2000_0000 + 32'(i*4));
    check("R4", log_a[base+4], 32'h0000_0010);

    // R5: strongly ordered write waits for drain, acked on bus completion
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h2000_0020, 32'h11, w, seen);
    req_wait(1'b1, 1'b0, 32'h0000_0024, 32'h22, w, seen);
    fork
      req_wait(1'b1, 1'b0, 32'hA000_0010, 32'h33, w, seen);
      raise_ready_after(3);
    join
    check("R5", seen, 32'hA000_0010);
    settle();
    check("R5", log_a[base], 32'h2000_0020);
    check("R5", log_a[base+1], 32'h0000_0024);
    check("R5", log_a[base+2], 32'hA000_0010);

    // R6: device read waits for device write, passes later normal write
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h2000_0080, 32'h44, w, seen);
    req_wait(1'b1, 1'b0, 32'h4000_0004, 32'h55, w, seen);
    req_wait(1'b1, 1'b0, 32'h6000_0008, 32'h66, w, seen);
    fork
      req_wait(1'b0, 1'b0, 32'h4000_0008, '0, w, seen);
      raise_ready_after(3);
    join
    @(negedge clk);
    // R10: data read from an execute-never region is not tagged
    check("R10", {30'd0, rsp_valid, rsp_xn}, {30'd0, 1'b1, 1'b0});
    settle();
    check("R6", log_a[base], 32'h2000_0080);
    check("R6", log_a[base+1], 32'h4000_0004);
    check("R6", log_a[base+2], 32'h4000_0008);
    check("R6", log_a[base+3], 32'h6000_0008);

    // R7: strongly ordered read waits for empty buffer
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h0000_0030, 32'h77, w, seen);
    req_wait(1'b1, 1'b0, 32'h2000_0034, 32'h88, w, seen);
    fork
      req_wait(1'b0, 1'b0, 32'hB000_0000, '0, w, seen);
      raise_ready_after(3);
    join
    settle();
    check("R7", log_a[base], 32'h0000_0030);
    check("R7", log_a[base+1], 32'h2000_0034);
    check("R7", log_a[base+2], 32'hB000_0000);

    // R8: non-matching normal read overtakes buffered writes
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h2000_0100, 32'h99, w, seen);
    req_wait(1'b1, 1'b0, 32'h2000_0104, 32'hAA, w, seen);
    fork
      req_wait(1'b0, 1'b0, 32'h0000_0208, '0, w, seen);
      raise_ready_after(3);
    join
    settle();
    check("R8", log_a[base], 32'h0000_0208);
    check("R8", log_a[base+1], 32'h2000_0100);
    check("R8", log_a[base+2], 32'h2000_0104);

    // R9: read matching the newest entry waits for it, returns its data
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h2000_0010, 32'h1111_1111, w, seen);
    req_wait(1'b1, 1'b0, 32'h2000_0014, 32'h2222_2222, w, seen);
    fork
      req_wait(1'b0, 1'b0, 32'h2000_0016, '0, w, seen);
      raise_ready_after(3);
    join
    @(negedge clk);
    check("R9", rsp_rdata, 32'h2222_2222);
    settle();
    check("R9", log_a[base+1], 32'h2000_0014);
    check("R9", log_a[base+2], 32'h2000_0016);

    // R9: read matching the head only slips in before the second write
    bus_ready = 1'b0;
    base = log_n;
    req_wait(1'b1, 1'b0, 32'h2000_0040, 32'h3333_3333, w, seen);
    req_wait(1'b1, 1'b0, 32'h2000_0044, 32'h4444_4444, w, seen);
    fork
      req_wait(1'b0, 1'b0, 32'h2000_0040, '0, w, seen);
      raise_ready_after(3);
    join
    @(negedge clk);
    // R10
    check("R10", {31'd0, rsp_valid}, 32'd1);
    check("R9", rsp_rdata, 32'h3333_3333);
    @(negedge clk);
    check("R10", {31'd0, rsp_valid}, 32'd0);
    settle();
    check("R9", log_a[base+1], 32'h2000_0040);
    check("R9", log_a[base+2], 32'h2000_0044);

    // R11: deferred execute-never fault
    req_wait(1'b0, 1'b1, 32'h4000_0020, '0, w, seen);
    @(negedge clk);
    check("R11", {30'd0, rsp_xn, xn_fault}, {30'd0, 1'b1, 1'b0});
    @(posedge clk); #1 exec_strobe = 1'b1;
    @(negedge clk);
    check("R11", {31'd0, xn_fault}, 32'd0);
    @(posedge clk); #1 exec_strobe = 1'b0;
    @(negedge clk);
    check("R11", {31'd0, xn_fault}, 32'd1);
    @(negedge clk);
    check("R11", {31'd0, xn_fault}, 32'd0);
    req_wait(1'b0, 1'b1, 32'h0000_0040, '0, w, seen);
    @(posedge clk); #1 exec_strobe = 1'b1;
    @(posedge clk); #1 exec_strobe = 1'b0;
    @(negedge clk);
    check("R11", {31'd0, xn_fault}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule